// File: doc/BRIEF.md
# Lane Edge Search Result Evaluator

This block judges one byte lane while a delay-line edge search is calibrating it. The search engine produces one result word per data bit. The block takes these words one at a time, for bit indices 0 to 7, over a valid/ready handshake. While it does so it decides whether the lane is still being evaluated or has failed, and in what way. It keeps the smallest and largest edge positions seen across the bits. From these it produces a delay shift value and a lock flag.

A pulse on `start` opens a pass. At that pulse two inputs are sampled. The first picks receive or transmit behaviour, which sets the result-field width, the code meaning "no edge", the direction in which an edge value is nudged, and whether the shift follows the maximum or the minimum. The second picks a normal pass or a retry pass. In a retry pass the lane locks only if every one of its bits succeeds. A one-cycle `done` pulse follows the bit with index 7.

Top module: `lane_edge_eval`

## Requirements
- R1: After reset, `status` is 3, `lock` is 0, `shift_val` is 0, `min_pos` is 0x1F, `max_pos` is 0, and `in_ready` and `done` are both 0.
- R2: A `start` pulse makes the following values visible in the next cycle: `status` 3, `max_pos` 0, `shift_val` 0, `in_ready` 1. It also sets `min_pos` to 0x1F when `tx_mode` is 0 and to 0x3F when `tx_mode` is 1. `lock` becomes 1 for a normal pass (`retry` 0) and 0 for a retry pass (`retry` 1).
- R3: In a normal pass, a word accepted in status 3 with bit 25 clear (the engine-success flag) sets `status` to 1 and `lock` to 0 on the next edge.
- R4: In a normal pass, take the masked field of a word accepted in status 3 with bit 25 set. In receive mode the field is bits [4:0]; in transmit mode it is bits [5:0]. If that field equals 0x1F in receive mode, or 0 in transmit mode, `status` becomes 4 and `lock` becomes 0.
- R5: Any other field is a valid edge. It is adjusted by +1 in receive mode and by -1 in transmit mode, and the adjusted value then updates `min_pos` and `max_pos`.
- R6: On each valid edge, `shift_val` takes the updated `max_pos` in receive mode and the updated `min_pos` in transmit mode. `shift_val` stays 0 while a pass has had no valid edge.
- R7: Once `status` has left 3, words accepted later in the same pass change none of `status`, `lock`, `min_pos`, `max_pos` or `shift_val`.
- R8: In a retry pass, an engine failure or a missing edge sets `status` to 2. After bit 7 is accepted, `lock` is 1 only if all 8 accepted bits were valid edges.
- R9: `done` is high for exactly one cycle, the cycle after the word with bit index 7 is accepted. `in_ready` is 0 from then until the next `start`.
- R10: `status` only ever takes the codes 1, 2, 3 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a pass and clears the lane state |
| tx_mode | input | 1 | Sampled at start: 0 selects receive, 1 selects transmit |
| retry | input | 1 | Sampled at start: 1 selects a retry pass |
| in_valid | input | 1 | A result word is offered |
| in_ready | output | 1 | High while the pass accepts words |
| in_bit | input | 3 | Bit index of the offered word |
| in_word | input | 32 | Search result word |
| status | output | 3 | Lane status code |
| lock | output | 1 | Lane lock flag |
| shift_val | output | 6 | Delay shift value |
| min_pos | output | 6 | Running minimum of adjusted edges |
| max_pos | output | 6 | Running maximum of adjusted edges |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
Two things can fall on the same clock edge: the lock decision at the end of a retry pass, and the classification of that pass's last bit. As a result, a failure on bit 7 and the final lock verdict are resolved together. Random passes in both modes, with and without retry, inject engine failures and missing edges at random bit positions, bit 7 included. After each `done` pulse, the status, lock, shift, minimum and maximum are compared with a reference computed in the bench from the requirements. Directed passes cover the field extremes that receive and transmit adjust to.

// File: rtl/lee_pkg.sv
package lee_pkg;
  typedef enum logic [2:0] {
    ST_ENG_FAIL   = 3'd1,
    ST_RETRY_FAIL = 3'd2,
    ST_EVAL       = 3'd3,
    ST_NO_EDGE    = 3'd4
  } lane_st_e;
endpackage

// File: rtl/lee_classify.sv
// Extracts the mode-dependent field, detects engine success and the edge,
// and produces the nudged edge position.
module lee_classify #(
  parameter int POS_W = 6,
  parameter int RX_W  = 5
) (
  input  logic             flag,
  input  logic [POS_W-1:0] raw,
  input  logic             mode_tx,
  output logic             eng_ok,
  output logic             edge_found,
  output logic [POS_W-1:0] adj_pos
);
  localparam logic [POS_W-1:0] RX_MASK = {{(POS_W-RX_W){1'b0}}, {RX_W{1'b1}}};
  localparam logic [POS_W-1:0] TX_MASK = {POS_W{1'b1}};

  logic [POS_W-1:0] field;

  always_comb begin
    field      = raw & (mode_tx ? TX_MASK : RX_MASK);
    eng_ok     = flag;
    edge_found = mode_tx ? (field != '0) : (field != RX_MASK);
    adj_pos    = mode_tx ? (field - 1'b1) : (field + 1'b1);
  end
endmodule

// File: rtl/lee_extreme.sv
// Running min/max of adjusted edges, plus the mode-selected shift value.
module lee_extreme #(
  parameter int POS_W = 6,
  parameter int RX_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             init_tx,
  input  logic             upd,
  input  logic             mode_tx,
  input  logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] min_q,
  output logic [POS_W-1:0] max_q,
  output logic [POS_W-1:0] shift_q
);
  localparam logic [POS_W-1:0] RX_TOP = {{(POS_W-RX_W){1'b0}}, {RX_W{1'b1}}};
  localparam logic [POS_W-1:0] TX_TOP = {POS_W{1'b1}};

  logic [POS_W-1:0] nmin, nmax;

  always_comb begin
    nmin = (pos < min_q) ? pos : min_q;
    nmax = (pos > max_q) ? pos : max_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      min_q   <= RX_TOP;
      max_q   <= '0;
      shift_q <= '0;
    end else if (init) begin
      min_q   <= init_tx ? TX_TOP : RX_TOP;
      max_q   <= '0;
      shift_q <= '0;
    end else if (upd) begin
      min_q   <= nmin;
      max_q   <= nmax;
      shift_q <= mode_tx ? nmin : nmax;
    end
  end
endmodule

// File: rtl/lane_edge_eval.sv
module lane_edge_eval #(
  parameter int WORD_W    = 32,
  parameter int FLAG_POS  = 25,
  parameter int POS_W     = 6,
  parameter int RX_W      = 5,
  parameter int LANE_BITS = 8,
  localparam int IDX_W    = $clog2(LANE_BITS),
  localparam int CNT_W    = $clog2(LANE_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tx_mode,
  input  logic              retry,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_bit,
  input  logic [WORD_W-1:0] in_word,
  output logic [2:0]        status,
  output logic              lock,
  output logic [POS_W-1:0]  shift_val,
  output logic [POS_W-1:0]  min_pos,
  output logic [POS_W-1:0]  max_pos,
  output logic              done
);
  import lee_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANE_BITS - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(LANE_BITS);

  logic             active_q, mode_q, retry_q, lock_q, done_q;
  lane_st_e         st_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             eng_ok, edge_found;
  logic [POS_W-1:0] adj_pos;
  logic             accept, evaluating, good, upd, last;

  lee_classify #(.POS_W(POS_W), .RX_W(RX_W)) u_cls (
    .flag       (in_word[FLAG_POS]),
    .raw        (in_word[POS_W-1:0]),
    .mode_tx    (mode_q),
    .eng_ok     (eng_ok),
    .edge_found (edge_found),
    .adj_pos    (adj_pos)
  );

  always_comb begin
    accept     = in_valid && active_q && !start;
    evaluating = accept && (st_q == ST_EVAL);
    good       = eng_ok && edge_found;
    upd        = evaluating && good;
    last       = accept && (in_bit == LAST_IDX);
    cnt_nx     = cnt_q + CNT_W'(upd && retry_q);
  end

  lee_extreme #(.POS_W(POS_W), .RX_W(RX_W)) u_ext (
    .clk     (clk),
    .rst     (rst),
    .init    (start),
    .init_tx (tx_mode),
    .upd     (upd),
    .mode_tx (mode_q),
    .pos     (adj_pos),
    .min_q   (min_pos),
    .max_q   (max_pos),
    .shift_q (shift_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      mode_q   <= 1'b0;
      retry_q  <= 1'b0;
      st_q     <= ST_EVAL;
      lock_q   <= 1'b0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      mode_q   <= tx_mode;
      retry_q  <= retry;
      st_q     <= ST_EVAL;
      lock_q   <= !retry;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last;
      cnt_q  <= cnt_nx;
      if (last) active_q <= 1'b0;
      if (evaluating && !good) begin
        lock_q <= 1'b0;
        if (retry_q)      st_q <= ST_RETRY_FAIL;
        else if (!eng_ok) st_q <= ST_ENG_FAIL;
        else              st_q <= ST_NO_EDGE;
      end
      if (last && retry_q) lock_q <= (cnt_nx == FULL_CNT);
    end
  end

  assign in_ready = active_q;
  assign status   = st_q;
  assign lock     = lock_q;
  assign done     = done_q;
endmodule

// File: rtl/lee_checker.sv
module lee_checker #(
  parameter int POS_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             in_ready,
  input logic             done,
  input logic [2:0]       status,
  input logic             lock,
  input logic [POS_W-1:0] shift_val,
  input logic [POS_W-1:0] min_pos,
  input logic [POS_W-1:0] max_pos
);
  a_r10_status_legal: assert property (@(posedge clk) disable iff (rst)
    (status >= 3'd1) && (status <= 3'd4));

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_ready_low_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);

  a_r7_frozen_values: assert property (@(posedge clk) disable iff (rst)
    (status != 3'd3 && !start) |=>
      ($stable(min_pos) && $stable(max_pos) && $stable(shift_val) && $stable(status)));

  a_r7_lock_stays_low: assert property (@(posedge clk) disable iff (rst)
    (status != 3'd3 && !start) |=> !lock);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (status == 3'd3 && max_pos == '0 && shift_val == '0 && in_ready));

  a_r8_lock_rise_source: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> (done || $past(start)));
endmodule

bind lane_edge_eval lee_checker #(.POS_W(POS_W)) u_lee_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .in_ready  (in_ready),
  .done      (done),
  .status    (status),
  .lock      (lock),
  .shift_val (shift_val),
  .min_pos   (min_pos),
  .max_pos   (max_pos)
);

// File: tb/tb_lane_edge_eval.sv
`timescale 1ns/1ps
module tb_lane_edge_eval;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, tx_mode = 1'b0, retry = 1'b0, in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_bit = '0;
  logic [31:0] in_word = '0;
  logic [2:0]  status;
  logic        lock, done;
  logic [5:0]  shift_val, min_pos, max_pos;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] w [8];

  always #2 clk = ~clk;

  lane_edge_eval dut (
    .clk(clk), .rst(rst), .start(start), .tx_mode(tx_mode), .retry(retry),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit), .in_word(in_word),
    .status(status), .lock(lock), .shift_val(shift_val), .min_pos(min_pos),
    .max_pos(max_pos), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference evaluation from the requirements, then drive and compare.
  task automatic run_pass(input bit tx, input bit rt, input string name);
    int st, mn, mx, lk, cnt, sh, f, adj;
    bit any;
    st = 3; mn = tx ? 63 : 31; mx = 0; lk = rt ? 0 : 1; cnt = 0; sh = 0; any = 0;
    for (int i = 0; i < 8; i++) begin
      if (st == 3) begin
        f = tx ? int'(w[i][5:0]) : int'(w[i][4:0]);
        if (!w[i][25]) begin st = rt ? 2 : 1; lk = 0; end
        else if ((tx && f == 0) || (!tx && f == 31)) begin st = rt ? 2 : 4; lk = 0; end
        else begin
          adj = tx ? f - 1 : f + 1;
          if (adj < mn) mn = adj;
          if (adj > mx) mx = adj;
          sh = tx ? mn : mx;
          any = 1; cnt++;
        end
      end
    end
    if (rt) lk = (cnt == 8) ? 1 : 0;
    if (!any) sh = 0;

    @(negedge clk); start = 1; tx_mode = tx; retry = rt;
    @(negedge clk); start = 0;
    chk({name, " R2 status after start"}, status, 3);
    chk({name, " R2 lock after start"}, lock, rt ? 0 : 1);
    chk({name, " R2 min after start"}, min_pos, tx ? 63 : 31);
    chk({name, " R2 ready after start"}, in_ready, 1);
    for (int i = 0; i < 8; i++) begin
      in_valid = 1; in_bit = 3'(i); in_word = w[i];
      @(negedge clk);
    end
    in_valid = 0;
    chk({name, " R9 done after bit 7"}, done, 1);
    chk({name, rt ? " R8 status" : " R3/R4 status"}, status, st);
    chk({name, rt ? " R8 lock" : " R7 lock"}, lock, lk);
    chk({name, " R5 min"}, min_pos, mn);
    chk({name, " R5 max"}, max_pos, mx);
    chk({name, " R6 shift"}, shift_val, sh);
    @(negedge clk);
    chk({name, " R9 done single cycle"}, done, 0);
    chk({name, " R9 ready low after pass"}, in_ready, 0);
  endtask

  function automatic logic [31:0] gen_word(input bit tx);
    logic [31:0] v;
    int r;
    v = $urandom;
    r = $urandom % 16;
    if (r == 0) v[25] = 1'b0;
    else if (r == 1) begin
      v[25] = 1'b1;
      if (tx) v[5:0] = 6'd0; else v[4:0] = 5'h1F;
    end else begin
      v[25] = 1'b1;
      if (tx && v[5:0] == 6'd0) v[5:0] = 6'd1;
      if (!tx && v[4:0] == 5'h1F) v[4:0] = 5'h1E;
    end
    return v;
  endfunction

  initial begin
    #800000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset status", status, 3);
    chk("R1 reset lock", lock, 0);
    chk("R1 reset shift", shift_val, 0);
    chk("R1 reset min", min_pos, 31);
    chk("R1 reset max", max_pos, 0);
    chk("R1 reset ready", in_ready, 0);
    chk("R1 reset done", done, 0);

    // Field extremes, receive: raw 0 -> 1, raw 30 -> 31; upper field bit ignored.
    for (int i = 0; i < 8; i++) w[i] = 32'h0200_0000 | 32'(5 + i);
    w[2] = 32'h0200_0000; w[5] = 32'h0200_0020 | 32'd30;
    run_pass(0, 0, "rx extremes");
    // Field extremes, transmit: raw 1 -> 0, raw 63 -> 62.
    for (int i = 0; i < 8; i++) w[i] = 32'h0200_0000 | 32'(20 + i);
    w[1] = 32'h0200_0001; w[6] = 32'h0200_003F;
    run_pass(1, 0, "tx extremes");
    // R7: engine failure on bit 0, later valid bits ignored.
    for (int i = 0; i < 8; i++) w[i] = 32'h0200_0000 | 32'(3 + i);
    w[0] = 32'h0000_0004;
    run_pass(0, 0, "R7 early fail rx");
    // R4 then ignored: no-edge in transmit on bit 3.
    for (int i = 0; i < 8; i++) w[i] = 32'h0200_0000 | 32'(40 - i);
    w[3] = 32'h0200_0040;
    run_pass(1, 0, "R4 no edge tx");
    // R8: retry with all valid, then with failure on bit 7.
    for (int i = 0; i < 8; i++) w[i] = 32'h0200_0000 | 32'(10 + i);
    run_pass(0, 1, "R8 retry all pass");
    w[7] = 32'h0000_000A;
    run_pass(1, 1, "R8 retry fail last");

    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 30; p++) begin
        for (int i = 0; i < 8; i++) w[i] = gen_word(m[0]);
        run_pass(m[0], m[1], "random");
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule